// File: doc/BRIEF.md
# UDP/IPv4 Frame Builder

This block turns a stream of 128-bit payload words into complete Ethernet II frames carrying IPv4 and UDP. A send command supplies a total byte count and a per-packet payload size. The block cuts the total into packets of that size, with a shorter final packet when a remainder is left. Each packet is loaded in full into an internal store before its header is built. While the words arrive, their 16-bit ones'-complement sum is accumulated, so the UDP checksum is already known when the first header byte leaves.

The frame is emitted on a 64-bit AXI4-Stream master. The header is made from the station's own and peer MAC addresses, own and peer IPv4 addresses, the own port, and the low half of a 32-bit peer port word. The IPv4 header is fixed at 20 bytes and carries the don't-fragment flag, a TTL of 64, protocol 17 and an identification that advances with every packet. Once the sink accepts the first word of a frame, the rest follows on back-to-back cycles. The sink is therefore expected to hold tready high until tlast.

Top module: `udpfb_top`

## Requirements
- R1: Frame byte n travels in word n/8 at tdata bits [8*(n%8)+7 : 8*(n%8)], and multi-byte fields are big-endian. Bytes 0-5 are the peer MAC and 6-11 the own MAC. Bytes 12-13 are 0x0800. Bytes 14-33 are the IPv4 header: 0x45, 0x00, total length P+28, identification, 0x4000, 0x40, 0x11, checksum, own IP, peer IP. Bytes 34-41 are the UDP header: own port, peer_port[15:0], length P+8, checksum.
- R2: Payload byte k of a 128-bit input word sits at bits [8k+7:8k]. Payload bytes appear from frame byte 42 onward, in input order.
- R3: The IPv4 header checksum makes the ones'-complement sum of the ten header halfwords equal 0xFFFF.
- R4: The UDP checksum covers the pseudo-header (both IPs, protocol 17, UDP length), the UDP header and the payload, so that the sum equals 0xFFFF. A computed value of zero is sent as 0xFFFF.
- R5: While tvalid is high and tready is low, tvalid, tdata, tkeep and tlast hold their values.
- R6: After any accepted word that is not the last, tvalid is high in the next cycle.
- R7: A frame with payload P has P/8+6 words. tkeep is 0xFF on every word except the last, where it is 0x03. tlast is high only on the last word, and tuser is always 0.
- R8: Bits [3:0] of total_len and pkt_len are ignored. pkt_len is clamped to between 16 and the maximum packet size (8960 by default). Packets take the clamped size, and the last one carries the remainder.
- R9: An accepted start raises busy in the next cycle. busy falls only in the cycle after the final word of the last packet is accepted. A start while busy, or with total_len[47:4] zero, is ignored.
- R10: The identification is 0 on the first packet after reset and increases by one on each packet, across commands.
- R11: Exactly P/16 payload words are accepted for a packet of P bytes, all of them before its first frame word is sent.
- R12: During and right after reset, tvalid, busy and pl_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a send command |
| total_len | input | 48 | Total bytes to send |
| pkt_len | input | 16 | Payload bytes per packet |
| busy | output | 1 | Command in progress |
| own_mac | input | 48 | Source MAC address |
| peer_mac | input | 48 | Destination MAC address |
| own_ip | input | 32 | Source IPv4 address |
| peer_ip | input | 32 | Destination IPv4 address |
| own_port | input | 16 | Source UDP port |
| peer_port | input | 32 | Peer ports; bits 15:0 used as destination port |
| pl_valid | input | 1 | Payload word valid |
| pl_data | input | 128 | Payload word |
| pl_ready | output | 1 | Payload word accepted when high with pl_valid |
| m_tdata | output | 64 | Stream data |
| m_tkeep | output | 8 | Stream byte enables |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | Last word of frame |
| m_tuser | output | 1 | Error flag, always 0 |
| m_tready | input | 1 | Sink ready |

## Verification
The bench goes after the remainder packet, the clamping of pkt_len at zero and above the maximum, and ignored low length bits. A design that got these wrong would send the wrong number of frames, or frames of the wrong length. It stalls tready before frames start, which exposes an output that changes while a word waits. It rebuilds every frame byte from the configuration and the payload sequence, so a halfword swap, a misplaced 2-byte header tail or a wrong last-word tkeep shows up as a byte miscompare. Both checksums are recomputed over the received bytes, and starts issued while busy or with a zero length are checked for having no effect.

// File: rtl/udpfb_pkg.sv
package udpfb_pkg;

  localparam int HDR_BYTES = 42;

  typedef struct packed {
    logic [47:0] own_mac;
    logic [47:0] peer_mac;
    logic [31:0] own_ip;
    logic [31:0] peer_ip;
    logic [15:0] own_port;
    logic [15:0] peer_port;
  } net_cfg_t;

  // ones'-complement partial sum of the eight network-order halfwords in a payload word
  function automatic logic [31:0] lane_sum(input logic [127:0] w);
    logic [31:0] s;
    s = '0;
    for (int m = 0; m < 8; m++) s += {16'h0, w[16*m +: 8], w[16*m+8 +: 8]};
    return s;
  endfunction

  function automatic logic [15:0] fold16(input logic [31:0] s);
    logic [16:0] a;
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    return a[15:0] + {15'h0, a[16]};
  endfunction

  function automatic logic [15:0] ip_csum(input net_cfg_t c, input logic [15:0] plen,
                                          input logic [15:0] id);
    logic [31:0] s;
    s = 32'h4500 + 32'(plen + 16'd28) + 32'(id) + 32'h4000 + 32'h4011 +
        32'(c.own_ip[31:16]) + 32'(c.own_ip[15:0]) +
        32'(c.peer_ip[31:16]) + 32'(c.peer_ip[15:0]);
    return ~fold16(s);
  endfunction

  function automatic logic [15:0] udp_csum(input net_cfg_t c, input logic [15:0] plen,
                                           input logic [31:0] psum);
    logic [31:0] s;
    logic [15:0] r;
    s = psum + 32'(c.own_ip[31:16]) + 32'(c.own_ip[15:0]) +
        32'(c.peer_ip[31:16]) + 32'(c.peer_ip[15:0]) + 32'd17 +
        {15'h0, plen + 16'd8, 1'b0} + 32'(c.own_port) + 32'(c.peer_port);
    r = ~fold16(s);
    return (r == 16'h0) ? 16'hFFFF : r;
  endfunction

  function automatic logic [8*HDR_BYTES-1:0] hdr_build(input net_cfg_t c, input logic [15:0] plen,
      input logic [15:0] id, input logic [15:0] ipck, input logic [15:0] udpck);
    logic [8*HDR_BYTES-1:0] h;
    logic [15:0] iplen, ulen;
    iplen = plen + 16'd28;
    ulen  = plen + 16'd8;
    h = '0;
    for (int i = 0; i < 6; i++) begin
      h[8*i +: 8]     = c.peer_mac[47-8*i -: 8];
      h[8*(6+i) +: 8] = c.own_mac[47-8*i -: 8];
    end
    h[8*12 +: 16] = {8'h00, 8'h08};
    h[8*14 +: 16] = {8'h00, 8'h45};
    h[8*16 +: 16] = {iplen[7:0], iplen[15:8]};
    h[8*18 +: 16] = {id[7:0], id[15:8]};
    h[8*20 +: 16] = {8'h00, 8'h40};
    h[8*22 +: 16] = {8'h11, 8'h40};
    h[8*24 +: 16] = {ipck[7:0], ipck[15:8]};
    for (int i = 0; i < 4; i++) begin
      h[8*(26+i) +: 8] = c.own_ip[31-8*i -: 8];
      h[8*(30+i) +: 8] = c.peer_ip[31-8*i -: 8];
    end
    h[8*34 +: 16] = {c.own_port[7:0], c.own_port[15:8]};
    h[8*36 +: 16] = {c.peer_port[7:0], c.peer_port[15:8]};
    h[8*38 +: 16] = {ulen[7:0], ulen[15:8]};
    h[8*40 +: 16] = {udpck[7:0], udpck[15:8]};
    return h;
  endfunction

endpackage

// File: rtl/udpfb_ctl.sv
module udpfb_ctl #(
  parameter int MAX_BYTES = 8960,
  parameter int WCW       = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_start,
  input  logic [47:0]    total_len,
  input  logic [15:0]    pkt_len,
  input  logic           fill_done,
  input  logic           send_done,
  output logic           busy,
  output logic           clr,
  output logic           fill_en,
  output logic           send_go,
  output logic [15:0]    cur_len,
  output logic [WCW-1:0] nwords
);
  typedef enum logic [1:0] {C_IDLE, C_PICK, C_FILL, C_SEND} cstate_t;
  cstate_t     state;
  logic [47:0] rem_q;
  logic [15:0] plen_q, cur_q;
  logic        cmd_ok;

  function automatic logic [15:0] clamp_len(input logic [15:0] p);
    logic [15:0] q;
    q = p & 16'hFFF0;
    if (q == 16'h0) q = 16'd16;
    if (32'(q) > MAX_BYTES) q = 16'(MAX_BYTES);
    return q;
  endfunction

  assign cmd_ok  = (state == C_IDLE) && cmd_start && (total_len[47:4] != '0);
  assign busy    = (state != C_IDLE);
  assign clr     = (state == C_PICK);
  assign fill_en = (state == C_FILL);
  assign send_go = (state == C_FILL) && fill_done;
  assign cur_len = cur_q;
  assign nwords  = WCW'(cur_q[15:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= C_IDLE;
      rem_q  <= '0;
      plen_q <= 16'd16;
      cur_q  <= 16'd16;
    end else begin
      case (state)
        C_IDLE: if (cmd_ok) begin
          rem_q  <= total_len & 48'hFFFF_FFFF_FFF0;
          plen_q <= clamp_len(pkt_len);
          state  <= C_PICK;
        end
        C_PICK: begin
          cur_q <= (rem_q < {32'h0, plen_q}) ? rem_q[15:0] : plen_q;
          state <= C_FILL;
        end
        C_FILL: if (fill_done) state <= C_SEND;
        C_SEND: if (send_done) begin
          rem_q <= rem_q - {32'h0, cur_q};
          state <= (rem_q == {32'h0, cur_q}) ? C_IDLE : C_PICK;
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(send_done)); // R9
  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_FILL) |-> (cur_q != 16'h0 && cur_q <= plen_q)); // R8

endmodule

// File: rtl/udpfb_pktbuf.sv
module udpfb_pktbuf
  import udpfb_pkg::*;
#(
  parameter int MAX_BYTES = 8960,
  localparam int WORDS = MAX_BYTES / 16,
  localparam int WIX   = $clog2(WORDS),
  localparam int WCW   = $clog2(WORDS + 1),
  localparam int AW    = $clog2(MAX_BYTES / 8 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           fill_en,
  input  logic [WCW-1:0] nwords,
  input  logic           pl_valid,
  input  logic [127:0]   pl_data,
  output logic           pl_ready,
  output logic           fill_done,
  output logic [31:0]    pay_sum,
  input  logic [AW-1:0]  rd_addr,
  output logic [63:0]    rd_data
);
  logic [WCW-1:0] wcnt;
  logic [31:0]    sum_q;
  logic           take;
  logic [AW-2:0]  ridx;
  logic           rd_ok;
  logic [63:0]    half_rd [2];

  assign pl_ready  = fill_en && (wcnt < nwords);
  assign take      = pl_ready && pl_valid;
  assign fill_done = fill_en && (wcnt == nwords);
  assign pay_sum   = sum_q;
  assign ridx      = rd_addr[AW-1:1];
  assign rd_ok     = (int'(ridx) < WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wcnt  <= '0;
      sum_q <= '0;
    end else if (take) begin
      wcnt  <= wcnt + 1'b1;
      sum_q <= sum_q + lane_sum(pl_data);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [63:0] store [WORDS];
    always_ff @(posedge clk) begin
      if (take) store[WIX'(wcnt)] <= pl_data[64*g +: 64];
    end
    assign half_rd[g] = rd_ok ? store[WIX'(ridx)] : 64'h0;
  end

  assign rd_data = rd_addr[0] ? half_rd[1] : half_rd[0];

  AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (wcnt <= nwords)); // R11

endmodule

// File: rtl/udpfb_tx.sv
module udpfb_tx
  import udpfb_pkg::*;
#(
  parameter int MAX_BYTES = 8960,
  localparam int AW = $clog2(MAX_BYTES / 8 + 1),
  localparam int XW = $clog2(MAX_BYTES / 8 + 7)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send_go,
  input  logic [15:0]   plen,
  input  logic [31:0]   pay_sum,
  input  net_cfg_t      cfg,
  output logic [AW-1:0] rd_addr,
  input  logic [63:0]   rd_data,
  output logic [63:0]   tdata,
  output logic [7:0]    tkeep,
  output logic          tvalid,
  output logic          tlast,
  output logic          tuser,
  input  logic          tready,
  output logic          send_done
);
  typedef enum logic [1:0] {T_IDLE, T_CALC, T_RUN} tstate_t;
  tstate_t                state;
  logic [15:0]            len_q, id_q, carry_q;
  logic [8*HDR_BYTES-1:0] hdr_q;
  logic [XW-1:0]          widx, last_idx;
  logic                   is_last, in_hdr, accept;
  logic [63:0]            hdr_word;
  logic [15:0]            low16;

  assign last_idx  = XW'(len_q[15:3]) + XW'(5);
  assign is_last   = (widx == last_idx);
  assign in_hdr    = (widx < XW'(5));
  assign tvalid    = (state == T_RUN);
  assign accept    = tvalid && tready;
  assign send_done = accept && is_last;
  assign tlast     = tvalid && is_last;
  assign tkeep     = !tvalid ? 8'h00 : (is_last ? 8'h03 : 8'hFF);
  assign tuser     = 1'b0;
  assign rd_addr   = in_hdr ? '0 : AW'(widx - XW'(5));
  assign low16     = (widx == XW'(5)) ? hdr_q[8*40 +: 16] : carry_q;

  always_comb begin
    case (widx[2:0])
      3'd0:    hdr_word = hdr_q[63:0];
      3'd1:    hdr_word = hdr_q[127:64];
      3'd2:    hdr_word = hdr_q[191:128];
      3'd3:    hdr_word = hdr_q[255:192];
      default: hdr_word = hdr_q[319:256];
    endcase
    if (!tvalid)      tdata = 64'h0;
    else if (in_hdr)  tdata = hdr_word;
    else if (is_last) tdata = {48'h0, low16};
    else              tdata = {rd_data[47:0], low16};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= T_IDLE;
      len_q   <= 16'd16;
      id_q    <= '0;
      carry_q <= '0;
      hdr_q   <= '0;
      widx    <= '0;
    end else begin
      case (state)
        T_IDLE: if (send_go) begin
          len_q <= plen;
          state <= T_CALC;
        end
        T_CALC: begin
          hdr_q <= hdr_build(cfg, len_q, id_q, ip_csum(cfg, len_q, id_q),
                             udp_csum(cfg, len_q, pay_sum));
          widx  <= '0;
          state <= T_RUN;
        end
        T_RUN: if (accept) begin
          if (!in_hdr) carry_q <= rd_data[63:48];
          widx <= widx + 1'b1;
          if (is_last) begin
            id_q  <= id_q + 16'd1;
            state <= T_IDLE;
          end
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tkeep) && $stable(tlast))); // R5
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tlast) |=> tvalid); // R6
  AST_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tlast) |-> (tkeep == 8'hFF)); // R7

endmodule

// File: rtl/udpfb_top.sv
module udpfb_top
  import udpfb_pkg::*;
#(
  parameter int MAX_BYTES = 8960,
  localparam int WORDS = MAX_BYTES / 16,
  localparam int WCW   = $clog2(WORDS + 1),
  localparam int AW    = $clog2(MAX_BYTES / 8 + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_start,
  input  logic [47:0]  total_len,
  input  logic [15:0]  pkt_len,
  output logic         busy,
  input  logic [47:0]  own_mac,
  input  logic [47:0]  peer_mac,
  input  logic [31:0]  own_ip,
  input  logic [31:0]  peer_ip,
  input  logic [15:0]  own_port,
  input  logic [31:0]  peer_port,
  input  logic         pl_valid,
  input  logic [127:0] pl_data,
  output logic         pl_ready,
  output logic [63:0]  m_tdata,
  output logic [7:0]   m_tkeep,
  output logic         m_tvalid,
  output logic         m_tlast,
  output logic         m_tuser,
  input  logic         m_tready
);
  net_cfg_t       cfg;
  logic           clr, fill_en, fill_done, send_go, send_done;
  logic [15:0]    cur_len;
  logic [WCW-1:0] nwords;
  logic [31:0]    pay_sum;
  logic [AW-1:0]  rd_addr;
  logic [63:0]    rd_data;

  assign cfg = '{own_mac: own_mac, peer_mac: peer_mac, own_ip: own_ip, peer_ip: peer_ip,
                 own_port: own_port, peer_port: peer_port[15:0]};

  udpfb_ctl #(.MAX_BYTES(MAX_BYTES), .WCW(WCW)) u_ctl (
    .clk, .rst_n, .cmd_start, .total_len, .pkt_len, .fill_done, .send_done,
    .busy, .clr, .fill_en, .send_go, .cur_len, .nwords);

  udpfb_pktbuf #(.MAX_BYTES(MAX_BYTES)) u_buf (
    .clk, .rst_n, .clr, .fill_en, .nwords, .pl_valid, .pl_data, .pl_ready,
    .fill_done, .pay_sum, .rd_addr, .rd_data);

  udpfb_tx #(.MAX_BYTES(MAX_BYTES)) u_tx (
    .clk, .rst_n, .send_go, .plen(cur_len), .pay_sum, .cfg, .rd_addr, .rd_data,
    .tdata(m_tdata), .tkeep(m_tkeep), .tvalid(m_tvalid), .tlast(m_tlast),
    .tuser(m_tuser), .tready(m_tready), .send_done);

  AST_FILL_BEFORE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !pl_ready); // R11

endmodule

// File: tb/sim_udpfb_top.sv
module sim_udpfb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         cmd_start = 0;
  logic [47:0]  total_len = 0;
  logic [15:0]  pkt_len = 0;
  logic         busy;
  logic [47:0]  own_mac = 0, peer_mac = 0;
  logic [31:0]  own_ip = 0, peer_ip = 0;
  logic [15:0]  own_port = 0;
  logic [31:0]  peer_port = 0;
  logic         pl_valid = 0;
  logic [127:0] pl_data = 0;
  logic         pl_ready;
  logic [63:0]  m_tdata;
  logic [7:0]   m_tkeep;
  logic         m_tvalid, m_tlast, m_tuser;
  logic         m_tready = 0;

  udpfb_top u0 (.*);

  int nchk = 0, nfail = 0;
  int pidx = 0, pay_base = 0;
  int exp_len [0:511];
  int exp_wr = 0, frames_rx = 0, exp_id = 0;
  logic [7:0] fr [0:9100];
  int nb = 0, wcount = 0;
  bit keep_bad = 0, midframe = 0, stall_prev = 0, gap_prev = 0, tuser_bad = 0;
  logic [63:0] p_data;
  logic [7:0] p_keep;
  logic p_last;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pay_word(input int j);
    logic [31:0] u;
    u = 32'(j);
    return {u * 32'h9E3779B9, u ^ 32'hA5A50F0F, ~(u * 32'h85EBCA6B), u + 32'h01234567};
  endfunction

  function automatic int ocfold(input int s);
    int t;
    t = s;
    while (t > 32'hFFFF) t = (t & 32'hFFFF) + (t >>> 16);
    return t;
  endfunction

  function automatic int clamp_bench(input int p);
    int q;
    q = p - (p % 16);
    if (q < 16) q = 16;
    if (q > 8960) q = 8960;
    return q;
  endfunction

  task automatic check_frame();
    int p, ok, bad, s, pb;
    logic [7:0] eh [0:41];
    logic [127:0] w;
    if (frames_rx >= exp_wr) begin
      chk(0, "R8 unexpected frame", frames_rx, exp_wr);
      return;
    end
    p = exp_len[frames_rx];
    chk(wcount == p / 8 + 6, "R7 word count", wcount, p / 8 + 6);
    chk(nb == p + 42, "R8 frame bytes", nb, p + 42);
    chk(!keep_bad && !tuser_bad, "R7 tkeep/tuser on body words", keep_bad, 0);
    for (int i = 0; i < 6; i++) begin
      eh[i] = peer_mac[47-8*i -: 8];
      eh[6+i] = own_mac[47-8*i -: 8];
    end
    eh[12] = 8'h08; eh[13] = 8'h00; eh[14] = 8'h45; eh[15] = 8'h00;
    eh[16] = 8'((p + 28) >> 8); eh[17] = 8'(p + 28);
    eh[18] = 8'(exp_id >> 8); eh[19] = 8'(exp_id);
    eh[20] = 8'h40; eh[21] = 8'h00; eh[22] = 8'h40; eh[23] = 8'h11;
    eh[24] = 0; eh[25] = 0;
    for (int i = 0; i < 4; i++) begin
      eh[26+i] = own_ip[31-8*i -: 8];
      eh[30+i] = peer_ip[31-8*i -: 8];
    end
    eh[34] = own_port[15:8]; eh[35] = own_port[7:0];
    eh[36] = peer_port[15:8]; eh[37] = peer_port[7:0];
    eh[38] = 8'((p + 8) >> 8); eh[39] = 8'(p + 8);
    eh[40] = 0; eh[41] = 0;
    bad = 0;
    for (int i = 0; i < 42; i++)
      if (i != 24 && i != 25 && i != 40 && i != 41 && i < nb && fr[i] !== eh[i]) bad++;
    chk(bad == 0, "R1 header fields", bad, 0);
    chk({fr[18], fr[19]} == 16'(exp_id), "R10 identification", {fr[18], fr[19]}, exp_id);
    bad = 0;
    for (int k = 0; k < p && 42 + k < nb; k++) begin
      w = pay_word(pay_base + k / 16);
      if (fr[42+k] !== w[8*(k%16) +: 8]) bad++;
    end
    chk(bad == 0, "R2 payload bytes", bad, 0);
    s = 0;
    for (int i = 0; i < 10; i++) s += {fr[14+2*i], fr[15+2*i]};
    chk(ocfold(s) == 32'hFFFF, "R3 ip checksum", ocfold(s), 32'hFFFF);
    s = own_ip[31:16] + own_ip[15:0] + peer_ip[31:16] + peer_ip[15:0] + 17 + p + 8;
    for (int i = 34; i + 1 < 42 + p && i + 1 < nb; i += 2) s += {fr[i], fr[i+1]};
    ok = (ocfold(s) == 32'hFFFF) && ({fr[40], fr[41]} != 16'h0);
    chk(ok != 0, "R4 udp checksum", ocfold(s), 32'hFFFF);
    pb = pay_base + p / 16;
    chk(pidx == pb, "R11 payload words per packet", pidx, pb);
    pay_base = pb;
    exp_id = (exp_id + 1) & 32'hFFFF;
    frames_rx++;
  endtask

  // payload source
  initial begin
    forever begin
      @(negedge clk);
      pl_valid = rst_n && ($urandom % 10 < 7);
      pl_data = pay_word(pidx);
      #1;
      if (pl_valid && pl_ready) pidx++;
    end
  end

  // stream sink and monitor
  initial begin
    forever begin
      @(negedge clk);
      m_tready = midframe ? 1'b1 : ($urandom % 10 < 6);
      #2;
      if (!rst_n) begin
        stall_prev = 0; gap_prev = 0;
      end else begin
        if (stall_prev)
          chk(m_tvalid && m_tdata == p_data && m_tkeep == p_keep && m_tlast == p_last,
              "R5 hold while stalled", m_tdata, p_data);
        if (gap_prev) chk(m_tvalid, "R6 no gap inside frame", m_tvalid, 1);
        if (m_tvalid && m_tuser) tuser_bad = 1;
        stall_prev = m_tvalid && !m_tready;
        gap_prev = m_tvalid && m_tready && !m_tlast;
        p_data = m_tdata; p_keep = m_tkeep; p_last = m_tlast;
        if (m_tvalid && m_tready) begin
          for (int b = 0; b < 8; b++)
            if (m_tkeep[b] && nb <= 9100) begin fr[nb] = m_tdata[8*b +: 8]; nb++; end
          if (!m_tlast && m_tkeep != 8'hFF) keep_bad = 1;
          wcount++;
          midframe = !m_tlast;
          if (m_tlast) begin
            chk(m_tkeep == 8'h03, "R7 last tkeep", m_tkeep, 8'h03);
            check_frame();
            nb = 0; wcount = 0; keep_bad = 0; tuser_bad = 0;
          end
        end
      end
    end
  end

  task automatic rand_cfg();
    own_mac = {$urandom, $urandom};
    peer_mac = {$urandom, $urandom};
    own_ip = $urandom; peer_ip = $urandom;
    own_port = 16'($urandom);
    peer_port = $urandom;
  endtask

  task automatic run_cmd(input longint total, input int pkt, input bit poke);
    longint t;
    int p;
    rand_cfg();
    t = total - (total % 16);
    p = clamp_bench(pkt);
    while (t > 0) begin
      exp_len[exp_wr] = (t < p) ? int'(t) : p;
      t -= exp_len[exp_wr];
      exp_wr++;
    end
    @(negedge clk);
    total_len = 48'(total); pkt_len = 16'(pkt); cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    #1 chk(busy == 1, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (15) @(negedge clk);
      total_len = 48'd64; pkt_len = 16'd16; cmd_start = 1;
      @(negedge clk);
      cmd_start = 0;
    end
    do begin
      @(negedge clk);
      #3;
    end while (busy);
    chk(frames_rx == exp_wr, "R9 busy fell after last frame", frames_rx, exp_wr);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    #1;
    chk(!m_tvalid && !busy && !pl_ready, "R12 in reset", {m_tvalid, busy, pl_ready}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(!m_tvalid && !busy && !pl_ready, "R12 after reset", {m_tvalid, busy, pl_ready}, 0);
    run_cmd(16, 16, 0);
    run_cmd(100, 32, 0);        // R8 low bits ignored: 96 bytes in three packets
    run_cmd(80, 48, 0);         // R8 remainder packet
    run_cmd(32, 0, 0);          // R8 clamp to 16
    run_cmd(8976, 9000, 0);     // R8 clamp to maximum, then 16-byte remainder
    run_cmd(160, 16, 1);        // R9 start while busy ignored
    @(negedge clk);
    total_len = 48'd15; pkt_len = 16'd16; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    #1 chk(busy == 0, "R9 zero length start ignored", busy, 0);
    repeat (5) @(negedge clk);
    #1 chk(frames_rx == exp_wr && !m_tvalid, "R9 no frame from ignored start", frames_rx, exp_wr);
    for (int i = 0; i < 12; i++)
      run_cmd(16 * (1 + $urandom % 64) + $urandom % 16, 16 * (1 + $urandom % 16) + $urandom % 16, 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d frames", frames_rx, exp_wr);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule